// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control sequencer for a multicycle processor datapath with one shared memory, one ALU and holding registers between the major units. It is a Moore state machine. A state register feeds two pieces of combinational logic: one computes the next state and the other turns the current state into the datapath controls. The controls are the memory read and write strobes, the memory address source, the instruction and program-counter load enables, the register-file write controls, the two ALU operand selects, the ALU function code and the program-counter source select.

Every instruction starts with a common fetch step and a common decode step. During fetch the program counter is advanced by four. During decode the branch target is computed ahead of time for every instruction, before the opcode is known. The opcode is examined only in decode, where it selects one of five instruction classes. Each class then runs its own short sequence of states and returns to fetch. A load takes five cycles, a store or register-register operation four, and a conditional branch or jump three.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in fetch. The state output uses this encoding: 0 fetch, 1 decode, 2 load address, 3 memory read, 4 load writeback, 5 store address, 6 memory write, 7 ALU execute, 8 ALU writeback, 9 branch, 10 jump.
- R2: Fetch drives the memory read strobe, the instruction load and the PC load. It selects the PC as memory address (address source 0), operand A source 0, operand B source 01, ALU function 00 and PC source 00.
- R3: Decode drives operand A source 0, operand B source 11 and ALU function 00, and asserts no write enable. It dispatches on the opcode: 0x23 goes to load address, 0x2B to store address, 0x00 to ALU execute, 0x04 to branch, 0x02 to jump, and any other value back to fetch.
- R4: Both address states drive operand A source 1, operand B source 10 and ALU function 00. Load address goes on to memory read. Store address goes on to memory write.
- R5: Memory read drives the memory read strobe with address source 1. Load writeback asserts the register write with destination select 0 and writeback-from-memory 1.
- R6: Memory write drives the memory write strobe with address source 1.
- R7: ALU execute drives operand A source 1, operand B source 00 and ALU function 10. ALU writeback asserts the register write with destination select 1 and writeback-from-memory 0.
- R8: Branch drives operand A source 1, operand B source 00, ALU function 01, PC source 01 and the conditional PC load.
- R9: Jump drives the PC load with PC source 10.
- R10: Cycle counts from fetch back to fetch are: load 5, store 4, ALU 4, branch 3, jump 3. Every final state of a class returns to fetch.
- R11: The opcode is sampled only in decode. A change of the opcode in later states does not change the path taken.
- R12: In every state, any enable or select field that the state does not list is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| state_o | output | 4 | Current state code |
| ram_rd_en | output | 1 | Memory read strobe |
| ram_wr_en | output | 1 | Memory write strobe |
| ram_addr_data | output | 1 | Memory address source: 0 PC, 1 ALU result register |
| ir_ld | output | 1 | Instruction register load |
| pc_ld | output | 1 | Unconditional PC load |
| pc_ld_eq | output | 1 | PC load when operands compare equal |
| rf_wr_en | output | 1 | Register-file write |
| rf_dst_rd | output | 1 | Destination field select: 1 third field, 0 second field |
| rf_src_mem | output | 1 | Writeback source: 1 memory data, 0 ALU result |
| opa_sel | output | 1 | ALU operand A source: 0 PC, 1 register A |
| opb_sel | output | 2 | ALU operand B source |
| alu_fn | output | 2 | ALU function code |
| pc_next_sel | output | 2 | PC source select |

## Verification
The assertions assume that reset is held for at least one clock edge before checking starts, and that the opcode input settles before the clock edge at which decode is left. The stimulus changes the opcode and reset only at falling edges, so both are stable at every rising edge. It holds each class's opcode from fetch through decode. In one run it deliberately changes the opcode after decode, to show that later states ignore it.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int ST_W = 4;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADR_LD = 4'd2,
        ST_MRD    = 4'd3,
        ST_LDWB   = 4'd4,
        ST_ADR_ST = 4'd5,
        ST_MWR    = 4'd6,
        ST_REXE   = 4'd7,
        ST_RWB    = 4'd8,
        ST_BR     = 4'd9,
        ST_JMP    = 4'd10
    } st_e;

    typedef struct packed {
        logic       ram_rd_en;
        logic       ram_wr_en;
        logic       ram_addr_data;
        logic       ir_ld;
        logic       pc_ld;
        logic       pc_ld_eq;
        logic       rf_wr_en;
        logic       rf_dst_rd;
        logic       rf_src_mem;
        logic       opa_sel;
        logic [1:0] opb_sel;
        logic [1:0] alu_fn;
        logic [1:0] pc_next_sel;
    } ctrl_t;

    localparam logic [1:0] OPB_REG   = 2'b00;
    localparam logic [1:0] OPB_FOUR  = 2'b01;
    localparam logic [1:0] OPB_IMM   = 2'b10;
    localparam logic [1:0] OPB_SHIMM = 2'b11;

    localparam logic [1:0] FN_ADD  = 2'b00;
    localparam logic [1:0] FN_SUB  = 2'b01;
    localparam logic [1:0] FN_FUNC = 2'b10;

    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_TGT  = 2'b01;
    localparam logic [1:0] PCS_JUMP = 2'b10;

    function automatic logic is_last(st_e s);
        return (s == ST_LDWB) || (s == ST_MWR) || (s == ST_RWB) ||
               (s == ST_BR)   || (s == ST_JMP);
    endfunction

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
    import mc_ctrl_pkg::*;
#(
    parameter int             OP_W  = 6,
    parameter logic [OP_W-1:0] OP_LD = 6'h23,
    parameter logic [OP_W-1:0] OP_ST = 6'h2B,
    parameter logic [OP_W-1:0] OP_RR = 6'h00,
    parameter logic [OP_W-1:0] OP_BR = 6'h04,
    parameter logic [OP_W-1:0] OP_JP = 6'h02
) (
    input  st_e             cur,
    input  logic [OP_W-1:0] opcode,
    output st_e             nxt
);
    always_comb begin
        nxt = ST_FETCH;
        if (is_last(cur)) begin
            nxt = ST_FETCH;
        end else begin
            unique case (cur)
                ST_FETCH:  nxt = ST_DECODE;
                ST_DECODE: begin
                    if      (opcode == OP_LD) nxt = ST_ADR_LD;
                    else if (opcode == OP_ST) nxt = ST_ADR_ST;
                    else if (opcode == OP_RR) nxt = ST_REXE;
                    else if (opcode == OP_BR) nxt = ST_BR;
                    else if (opcode == OP_JP) nxt = ST_JMP;
                    else                      nxt = ST_FETCH;
                end
                ST_ADR_LD: nxt = ST_MRD;
                ST_MRD:    nxt = ST_LDWB;
                ST_ADR_ST: nxt = ST_MWR;
                ST_REXE:   nxt = ST_RWB;
                default:   nxt = ST_FETCH;
            endcase
        end
    end
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
    import mc_ctrl_pkg::*;
(
    input  st_e   cur,
    output ctrl_t ctl
);
    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.ram_rd_en   = 1'b1;
                ctl.ir_ld       = 1'b1;
                ctl.pc_ld       = 1'b1;
                ctl.opb_sel     = OPB_FOUR;
                ctl.alu_fn      = FN_ADD;
                ctl.pc_next_sel = PCS_ALU;
            end
            ST_DECODE: begin
                ctl.opb_sel = OPB_SHIMM;
                ctl.alu_fn  = FN_ADD;
            end
            ST_ADR_LD, ST_ADR_ST: begin
                ctl.opa_sel = 1'b1;
                ctl.opb_sel = OPB_IMM;
                ctl.alu_fn  = FN_ADD;
            end
            ST_MRD: begin
                ctl.ram_rd_en     = 1'b1;
                ctl.ram_addr_data = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_wr_en   = 1'b1;
                ctl.rf_src_mem = 1'b1;
            end
            ST_MWR: begin
                ctl.ram_wr_en     = 1'b1;
                ctl.ram_addr_data = 1'b1;
            end
            ST_REXE: begin
                ctl.opa_sel = 1'b1;
                ctl.opb_sel = OPB_REG;
                ctl.alu_fn  = FN_FUNC;
            end
            ST_RWB: begin
                ctl.rf_wr_en  = 1'b1;
                ctl.rf_dst_rd = 1'b1;
            end
            ST_BR: begin
                ctl.opa_sel     = 1'b1;
                ctl.opb_sel     = OPB_REG;
                ctl.alu_fn      = FN_SUB;
                ctl.pc_next_sel = PCS_TGT;
                ctl.pc_ld_eq    = 1'b1;
            end
            ST_JMP: begin
                ctl.pc_ld       = 1'b1;
                ctl.pc_next_sel = PCS_JUMP;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int              OP_W  = 6,
    parameter logic [OP_W-1:0] OP_LD = 6'h23,
    parameter logic [OP_W-1:0] OP_ST = 6'h2B,
    parameter logic [OP_W-1:0] OP_RR = 6'h00,
    parameter logic [OP_W-1:0] OP_BR = 6'h04,
    parameter logic [OP_W-1:0] OP_JP = 6'h02
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic [3:0]      state_o,
    output logic            ram_rd_en,
    output logic            ram_wr_en,
    output logic            ram_addr_data,
    output logic            ir_ld,
    output logic            pc_ld,
    output logic            pc_ld_eq,
    output logic            rf_wr_en,
    output logic            rf_dst_rd,
    output logic            rf_src_mem,
    output logic            opa_sel,
    output logic [1:0]      opb_sel,
    output logic [1:0]      alu_fn,
    output logic [1:0]      pc_next_sel
);
    st_e   cur_q;
    st_e   nxt;
    ctrl_t ctl;

    mc_ctrl_next #(
        .OP_W(OP_W), .OP_LD(OP_LD), .OP_ST(OP_ST),
        .OP_RR(OP_RR), .OP_BR(OP_BR), .OP_JP(OP_JP)
    ) u_next (
        .cur(cur_q), .opcode(opcode), .nxt(nxt)
    );

    mc_ctrl_out u_out (
        .cur(cur_q), .ctl(ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_q <= ST_FETCH;
        else     cur_q <= nxt;
    end

    assign state_o       = cur_q;
    assign ram_rd_en     = ctl.ram_rd_en;
    assign ram_wr_en     = ctl.ram_wr_en;
    assign ram_addr_data = ctl.ram_addr_data;
    assign ir_ld         = ctl.ir_ld;
    assign pc_ld         = ctl.pc_ld;
    assign pc_ld_eq      = ctl.pc_ld_eq;
    assign rf_wr_en      = ctl.rf_wr_en;
    assign rf_dst_rd     = ctl.rf_dst_rd;
    assign rf_src_mem    = ctl.rf_src_mem;
    assign opa_sel       = ctl.opa_sel;
    assign opb_sel       = ctl.opb_sel;
    assign alu_fn        = ctl.alu_fn;
    assign pc_next_sel   = ctl.pc_next_sel;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk #(
    parameter int              OP_W  = 6,
    parameter logic [OP_W-1:0] OP_LD = 6'h23,
    parameter logic [OP_W-1:0] OP_ST = 6'h2B,
    parameter logic [OP_W-1:0] OP_JP = 6'h02
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] opcode,
    input logic [3:0]      state_o,
    input logic            ram_rd_en,
    input logic            ram_wr_en,
    input logic            rf_wr_en,
    input logic            pc_ld_eq,
    input logic [1:0]      alu_fn
);
    a_r1_reset_to_fetch: assert property (@(posedge clk)
        rst |=> state_o == 4'd0);

    a_r3_load_dispatch: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd1 && opcode == OP_LD) |=> state_o == 4'd2);

    a_r3_store_dispatch: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd1 && opcode == OP_ST) |=> state_o == 4'd5);

    a_r9_jump_dispatch: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd1 && opcode == OP_JP) |=> state_o == 4'd10);

    a_r4_load_path: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd2 |=> state_o == 4'd3);

    a_r10_last_returns: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd4 || state_o == 4'd6 || state_o == 4'd8 ||
         state_o == 4'd9 || state_o == 4'd10) |=> state_o == 4'd0);

    a_r12_no_rd_wr_clash: assert property (@(posedge clk) disable iff (rst)
        !(ram_rd_en && ram_wr_en));

    a_r12_no_rf_and_mem_wr: assert property (@(posedge clk) disable iff (rst)
        !(rf_wr_en && ram_wr_en));

    a_r8_cond_load_subtracts: assert property (@(posedge clk) disable iff (rst)
        pc_ld_eq |-> alu_fn == 2'b01);
endmodule

bind mc_ctrl_fsm mc_ctrl_chk #(
    .OP_W(OP_W), .OP_LD(OP_LD), .OP_ST(OP_ST), .OP_JP(OP_JP)
) u_chk (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .rf_wr_en(rf_wr_en),
    .pc_ld_eq(pc_ld_eq), .alu_fn(alu_fn)
);

// File: tb/sim_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module sim_mc_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic [3:0] state_o;
    logic       ram_rd_en, ram_wr_en, ram_addr_data, ir_ld, pc_ld, pc_ld_eq;
    logic       rf_wr_en, rf_dst_rd, rf_src_mem, opa_sel;
    logic [1:0] opb_sel, alu_fn, pc_next_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mc_ctrl_fsm u0 (
        .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
        .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
        .ram_addr_data(ram_addr_data), .ir_ld(ir_ld), .pc_ld(pc_ld),
        .pc_ld_eq(pc_ld_eq), .rf_wr_en(rf_wr_en), .rf_dst_rd(rf_dst_rd),
        .rf_src_mem(rf_src_mem), .opa_sel(opa_sel), .opb_sel(opb_sel),
        .alu_fn(alu_fn), .pc_next_sel(pc_next_sel)
    );

    // Packed: rd wr adr ir pc pceq rfwr dst srcmem opa opb[2] fn[2] pcs[2]
    function automatic logic [15:0] exp_word(input logic [3:0] s);
        case (s)
            4'd0:       return 16'b1_0_0_1_1_0_0_0_0_0_01_00_00; // R2
            4'd1:       return 16'b0_0_0_0_0_0_0_0_0_0_11_00_00; // R3
            4'd2, 4'd5: return 16'b0_0_0_0_0_0_0_0_0_1_10_00_00; // R4
            4'd3:       return 16'b1_0_1_0_0_0_0_0_0_0_00_00_00; // R5
            4'd4:       return 16'b0_0_0_0_0_0_1_0_1_0_00_00_00; // R5
            4'd6:       return 16'b0_1_1_0_0_0_0_0_0_0_00_00_00; // R6
            4'd7:       return 16'b0_0_0_0_0_0_0_0_0_1_00_10_00; // R7
            4'd8:       return 16'b0_0_0_0_0_0_1_1_0_0_00_00_00; // R7
            4'd9:       return 16'b0_0_0_0_0_1_0_0_0_1_00_01_01; // R8
            4'd10:      return 16'b0_0_0_0_1_0_0_0_0_0_00_00_10; // R9
            default:    return 16'h0000;                         // R12
        endcase
    endfunction

    function automatic logic [15:0] act_word();
        return {ram_rd_en, ram_wr_en, ram_addr_data, ir_ld, pc_ld, pc_ld_eq,
                rf_wr_en, rf_dst_rd, rf_src_mem, opa_sel, opb_sel, alu_fn,
                pc_next_sel};
    endfunction

    task automatic chk(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts and ends at a falling edge while in fetch.
    task automatic run_class(input string req, input logic [5:0] op,
                             input logic [5:0] op_late, input int n,
                             input logic [3:0] s0, input logic [3:0] s1,
                             input logic [3:0] s2, input logic [3:0] s3,
                             input logic [3:0] s4);
        logic [3:0] seq [5];
        seq = '{s0, s1, s2, s3, s4};
        opcode = op;
        for (int i = 0; i < n; i++) begin
            if (i >= 2) opcode = op_late;
            chk({req, " state"}, {12'h0, state_o}, {12'h0, seq[i]});
            chk({req, " ctrl R12"}, act_word(), exp_word(seq[i]));
            @(posedge clk);
            @(negedge clk);
        end
        chk({req, " R10 back to fetch"}, {12'h0, state_o}, 16'h0);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", {12'h0, state_o}, 16'h0);
        chk("R1 reset ctrl", act_word(), exp_word(4'd0));
        rst = 1'b0;
    endtask

    task automatic test_reset_mid();
        opcode = 6'h23;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R1 mid setup", {12'h0, state_o}, 16'h2);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 mid reset", {12'h0, state_o}, 16'h0);
        rst = 1'b0;
    endtask

    initial begin
        test_reset();
        run_class("R4 R5 load",  6'h23, 6'h23, 5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4);
        run_class("R4 R6 store", 6'h2B, 6'h2B, 4, 4'd0, 4'd1, 4'd5, 4'd6, 4'd0);
        run_class("R7 alu",      6'h00, 6'h00, 4, 4'd0, 4'd1, 4'd7, 4'd8, 4'd0);
        run_class("R8 branch",   6'h04, 6'h04, 3, 4'd0, 4'd1, 4'd9, 4'd0, 4'd0);
        run_class("R9 jump",     6'h02, 6'h02, 3, 4'd0, 4'd1, 4'd10, 4'd0, 4'd0);
        run_class("R3 unknown",  6'h3F, 6'h3F, 2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0);
        run_class("R11 load late op", 6'h23, 6'h2B, 5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4);
        run_class("R11 store late op", 6'h2B, 6'h23, 4, 4'd0, 4'd1, 4'd5, 4'd6, 4'd0);
        run_class("R11 alu late op", 6'h00, 6'h04, 4, 4'd0, 4'd1, 4'd7, 4'd8, 4'd0);
        test_reset_mid();
        run_class("R10 jump after reset", 6'h02, 6'h02, 3, 4'd0, 4'd1, 4'd10, 4'd0, 4'd0);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule